// File: doc/BRIEF.md
# Transmit Frame Assembler

This block gathers the 32-bit words that software writes for an outgoing Ethernet frame and places them in a word-organised buffer of 2048 bytes. The first word written into an empty buffer carries the payload length in its low half. From that length the block works out when enough bytes are present for a whole frame and, if a fill threshold has been programmed, starts sending on its own. Software can also force a send at any time with a trigger write.

Sending streams the frame out one byte per cycle under a valid/ready handshake, starting at buffer byte 2, so the two length bytes are never sent. Short frames may be zero-padded to the minimum Ethernet size. When the last byte leaves, the buffer is emptied and a one-cycle empty event is raised. A length that is too large is refused with a one-cycle error event, and acknowledging that error empties the buffer.

Top module: `tx_frame_asm`

## Requirements
- R1: After reset no byte is offered (`tx_valid_o` low), `wr_ready_o` is high, both events are low, the buffer is empty and the fill threshold is disabled (value 63).
- R2: When the buffer is empty, a data word whose low 16 bits exceed 2032 is discarded and `tx_err_evt_o` is high for one cycle, in the cycle after the write. A length of exactly 2032 is accepted.
- R3: A frame is complete when the fill reaches length+16 bytes with `crc_auto_i` high, or length+20 bytes with it low. The target never exceeds 2048.
- R4: The threshold is met only when its 6-bit value is below 63 and the fill is at least 32*value+4 bytes. Value 63 disables sending on fill.
- R5: A send starts on its own only after an accepted data write that leaves the threshold met and the frame complete. `tx_valid_o` rises in the cycle after that write.
- R6: A trigger write (`kick_we_i`) with `kick_data_i` bit 0 set starts a send in the next cycle whatever the fill. With bit 0 clear it does nothing.
- R7: The frame is length+14 bytes taken from buffer byte 2 onward. Buffer byte 4w+k is bits 8k+7:8k of data word w (little-endian). `tx_last_o` marks only the final byte, and the length is capped at 2046.
- R8: With `pad_en_i` high, a frame shorter than 60 bytes is sent as 60 bytes, and every byte past length+14 is zero. With `pad_en_i` low, no padding is added.
- R9: A data write that would bring the fill above 2048 bytes is dropped and leaves the buffer contents unchanged.
- R10: While a frame is streaming, `wr_ready_o` is low and data writes have no effect. A byte that is offered but not accepted is held stable.
- R11: One cycle after the final byte is accepted, `tx_empty_evt_o` pulses for one cycle, the buffer is empty and `wr_ready_o` is high again.
- R12: A pulse on `err_ack_i` empties the buffer when no frame is streaming, so the next data word is taken as a new length word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Data word write strobe |
| wr_data_i | input | 32 | Data word |
| wr_ready_o | output | 1 | Writes are accepted (no frame streaming) |
| crc_auto_i | input | 1 | Auto-CRC enabled; completion needs no CRC bytes in the buffer |
| pad_en_i | input | 1 | Pad short frames to 60 bytes |
| thr_we_i | input | 1 | Load the fill threshold |
| thr_data_i | input | 6 | New threshold value, 63 disables |
| kick_we_i | input | 1 | Trigger register write strobe |
| kick_data_i | input | 32 | Trigger write data, bit 0 requests a send |
| err_ack_i | input | 1 | Acknowledge of the error event; empties the buffer |
| tx_valid_o | output | 1 | Byte available |
| tx_ready_i | input | 1 | Sink takes the byte |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_empty_evt_o | output | 1 | One-cycle pulse: frame sent, buffer empty |
| tx_err_evt_o | output | 1 | One-cycle pulse: length word refused |

## Verification
The hardest case to reach is the full buffer. A write must be refused because of room alone, and the refusal must still be shown to have no effect. The stimulus fills all 512 words with the threshold disabled, so nothing can leave early. It then enables a threshold of zero and writes one more distinctive word. That write is dropped, yet it passes the send test against the capped 2048-byte target. The 2046-byte frame that follows is compared byte by byte, which shows the tail still holds the original last word. A second hard case is a write attempted during streaming. Each received frame is sent while a write strobe is held high, and any word wrongly accepted would corrupt the length parsing of the next frame.

// File: rtl/txa_pkg.sv
package txa_pkg;
  localparam int unsigned LEN_W    = 16;
  localparam int unsigned THR_W    = 6;
  localparam logic [5:0]  THR_OFF  = 6'h3f;
  localparam int unsigned HDR_SKIP = 2;   // length bytes not sent
  localparam int unsigned ETH_HDR  = 14;
  localparam int unsigned CPL_OVH  = 16;  // length bytes + header
  localparam int unsigned CRC_B    = 4;
  localparam int unsigned PAD_MIN  = 60;
endpackage

// File: rtl/txa_buf.sv
module txa_buf #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned WORDS = DEPTH / 4,
  localparam int unsigned WAW   = $clog2(WORDS),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [WAW-1:0] waddr_i,
  input  logic [31:0]    wdata_i,
  input  logic [AW-1:0]  raddr_i,
  output logic [7:0]     rbyte_o
);
  logic [31:0] mem_q [WORDS];
  logic [31:0] rword;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rword   = mem_q[raddr_i[AW-1:2]];
  assign rbyte_o = rword[8*raddr_i[1:0] +: 8];
endmodule

// File: rtl/txa_ctrl.sv
module txa_ctrl
  import txa_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned FW   = $clog2(DEPTH + 1),
  localparam int unsigned WAW  = $clog2(DEPTH / 4),
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = LEN_W + 1,
  localparam int unsigned MAX_LEN = DEPTH - CPL_OVH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [31:0]      wr_data_i,
  input  logic             crc_auto_i,
  input  logic             pad_en_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_data_i,
  input  logic             kick_we_i,
  input  logic [31:0]      kick_data_i,
  input  logic             err_ack_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             mem_we_o,
  output logic [WAW-1:0]   mem_waddr_o,
  output logic             start_o,
  output logic [AW-1:0]    flen_o,
  output logic [AW-1:0]    dlen_o,
  output logic [FW-1:0]    fill_o,
  output logic             err_evt_o,
  output logic             empty_evt_o
);
  logic [FW-1:0]    fill_q, fill_nxt;
  logic [LEN_W-1:0] len_q, len_nxt;
  logic [THR_W-1:0] thr_q;
  logic             err_q, empty_q;
  logic             fill_zero, wr_take, len_bad, room, complete, thr_hit;
  logic [CW-1:0]    tgt_raw, tgt, thr_lvl, fill_ext, dlen_raw, dlen_cap, flen_pad;

  assign fill_zero = (fill_q == '0);
  assign wr_take   = wr_valid_i & ~busy_i & ~err_ack_i;
  assign len_bad   = fill_zero && (wr_data_i[LEN_W-1:0] > LEN_W'(MAX_LEN));
  assign room      = ({1'b0, fill_q} + (FW+1)'(4)) <= (FW+1)'(DEPTH);
  assign mem_we_o  = wr_take & ~len_bad & room;
  assign mem_waddr_o = fill_q[WAW+1:2];

  assign fill_nxt = mem_we_o ? fill_q + FW'(4) : fill_q;
  assign len_nxt  = (mem_we_o && fill_zero) ? wr_data_i[LEN_W-1:0] : len_q;

  // completion target, capped at buffer size
  assign tgt_raw  = CW'(len_nxt) + CW'(CPL_OVH) + (crc_auto_i ? CW'(0) : CW'(CRC_B));
  assign tgt      = (tgt_raw > CW'(DEPTH)) ? CW'(DEPTH) : tgt_raw;
  assign fill_ext = CW'(fill_nxt);
  assign complete = fill_ext >= tgt;
  assign thr_lvl  = (CW'(thr_q) << 5) + CW'(4);
  assign thr_hit  = (thr_q != THR_OFF) && (fill_ext >= thr_lvl);

  assign start_o = (wr_take & ~len_bad & thr_hit & complete)
                 | (kick_we_i & kick_data_i[0] & ~busy_i);

  assign dlen_raw = CW'(len_nxt) + CW'(ETH_HDR);
  assign dlen_cap = (dlen_raw > CW'(DEPTH - HDR_SKIP)) ? CW'(DEPTH - HDR_SKIP) : dlen_raw;
  assign flen_pad = (pad_en_i && dlen_cap < CW'(PAD_MIN)) ? CW'(PAD_MIN) : dlen_cap;
  assign dlen_o   = AW'(dlen_cap);
  assign flen_o   = AW'(flen_pad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      len_q   <= '0;
      thr_q   <= THR_OFF;
      err_q   <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      if (done_i || (err_ack_i && !busy_i)) fill_q <= '0;
      else                                   fill_q <= fill_nxt;
      len_q   <= len_nxt;
      if (thr_we_i) thr_q <= thr_data_i;
      err_q   <= wr_take & len_bad;
      empty_q <= done_i;
    end
  end

  assign fill_o      = fill_q;
  assign err_evt_o   = err_q;
  assign empty_evt_o = empty_q;

  assert_fill_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FW'(DEPTH));
  assert_len_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LEN_W'(MAX_LEN));
  assert_fill_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> fill_q == $past(fill_q));
  assert_ack_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ack_i && !busy_i |=> fill_q == '0);
endmodule

// File: rtl/txa_stream.sv
module txa_stream #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] flen_i,
  input  logic [AW-1:0] dlen_i,
  input  logic [7:0]    rbyte_i,
  output logic [AW-1:0] raddr_o,
  input  logic          tx_ready_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  output logic          busy_o,
  output logic          done_o
);
  logic          busy_q;
  logic [AW-1:0] cnt_q, flen_q, dlen_q;

  assign raddr_o    = cnt_q + AW'(txa_pkg::HDR_SKIP);
  assign tx_valid_o = busy_q;
  assign tx_data_o  = (cnt_q >= dlen_q) ? 8'h00 : rbyte_i;  // pad zone
  assign tx_last_o  = busy_q && (cnt_q == flen_q - AW'(1));
  assign done_o     = busy_q & tx_ready_i & tx_last_o;
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      flen_q <= '0;
      dlen_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      flen_q <= flen_i;
      dlen_q <= dlen_i;
    end else if (busy_q && tx_ready_i) begin
      if (tx_last_o) busy_q <= 1'b0;
      else           cnt_q  <= cnt_q + AW'(1);
    end
  end

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));
  assert_len_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> flen_q >= AW'(txa_pkg::ETH_HDR));
  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/tx_frame_asm.sv
module tx_frame_asm #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned WAW  = $clog2(DEPTH / 4),
  localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_valid_i,
  input  logic [31:0] wr_data_i,
  output logic        wr_ready_o,
  input  logic        crc_auto_i,
  input  logic        pad_en_i,
  input  logic        thr_we_i,
  input  logic [5:0]  thr_data_i,
  input  logic        kick_we_i,
  input  logic [31:0] kick_data_i,
  input  logic        err_ack_i,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  output logic        tx_empty_evt_o,
  output logic        tx_err_evt_o
);
  logic           mem_we, start, busy, done;
  logic [WAW-1:0] mem_waddr;
  logic [AW-1:0]  flen, dlen, raddr;
  logic [7:0]     rbyte;
  logic [FW-1:0]  fill;

  txa_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i, .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rbyte_o(rbyte)
  );

  txa_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_valid_i, .wr_data_i, .crc_auto_i, .pad_en_i,
    .thr_we_i, .thr_data_i, .kick_we_i, .kick_data_i, .err_ack_i,
    .busy_i(busy), .done_i(done), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
    .start_o(start), .flen_o(flen), .dlen_o(dlen), .fill_o(fill),
    .err_evt_o(tx_err_evt_o), .empty_evt_o(tx_empty_evt_o)
  );

  txa_stream #(.DEPTH(DEPTH)) u_stream (
    .clk_i, .rst_ni, .start_i(start), .flen_i(flen), .dlen_i(dlen),
    .rbyte_i(rbyte), .raddr_o(raddr), .tx_ready_i, .tx_valid_o,
    .tx_data_o, .tx_last_o, .busy_o(busy), .done_o(done)
  );

  assign wr_ready_o = ~busy;

  assert_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> fill == '0 && tx_empty_evt_o && wr_ready_o);
  assert_start_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> tx_valid_o);
endmodule

// File: tb/tx_frame_asm_bench.sv
`timescale 1ns/1ps
module tx_frame_asm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid_i = 0, crc_auto_i = 1, pad_en_i = 0, thr_we_i = 0;
  logic        kick_we_i = 0, err_ack_i = 0, tx_ready_i = 0;
  logic [31:0] wr_data_i = '0, kick_data_i = '0;
  logic [5:0]  thr_data_i = '0;
  logic        wr_ready_o, tx_valid_o, tx_last_o, tx_empty_evt_o, tx_err_evt_o;
  logic [7:0]  tx_data_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] bm [2048];
  int bfill = 0;

  always #10 clk = ~clk;

  tx_frame_asm u_tx_frame_asm (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i, .wr_data_i, .wr_ready_o,
    .crc_auto_i, .pad_en_i, .thr_we_i, .thr_data_i, .kick_we_i, .kick_data_i,
    .err_ack_i, .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_last_o,
    .tx_empty_evt_o, .tx_err_evt_o
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [31:0] d);
    if (!(bfill == 0 && d[15:0] > 16'd2032) && bfill + 4 <= 2048) begin
      for (int k = 0; k < 4; k++) bm[bfill + k] = d[8*k +: 8];
      bfill += 4;
    end
    wr_valid_i = 1; wr_data_i = d;
    @(negedge clk);
    wr_valid_i = 0;
  endtask

  task automatic set_thr(input logic [5:0] v);
    thr_we_i = 1; thr_data_i = v;
    @(negedge clk);
    thr_we_i = 0;
  endtask

  task automatic kick(input logic [31:0] d);
    kick_we_i = 1; kick_data_i = d;
    @(negedge clk);
    kick_we_i = 0;
  endtask

  task automatic recv(input int exp_len, input int dlen, input string req, input bit bp);
    int n = 0, bad = 0, wbusy = 0, cyc = 0, first_bad = -1;
    bit fin = 0;
    int act_b = 0, exp_b = 0;
    wr_valid_i = 1; wr_data_i = 32'h0000_0001;  // must be refused while streaming
    while (!fin && cyc < 5000) begin
      tx_ready_i = bp ? (cyc % 3 != 0) : 1'b1;
      if (tx_valid_o && wr_ready_o) wbusy++;
      if (tx_valid_o && tx_ready_i) begin
        logic [7:0] e;
        e = (n >= dlen) ? 8'h00 : bm[n + 2];
        if (tx_data_o !== e && first_bad < 0) begin
          first_bad = n; act_b = tx_data_o; exp_b = e;
        end
        if (tx_data_o !== e) bad++;
        if (tx_last_o) fin = 1;
        n++;
      end
      cyc++;
      @(negedge clk);
    end
    tx_ready_i = 0; wr_valid_i = 0;
    chk(n == exp_len, req, "frame length", n, exp_len);
    chk(bad == 0, req, $sformatf("byte %0d value", first_bad), act_b, exp_b);
    chk(wbusy == 0, "R10", "cycles with wr_ready high while streaming", wbusy, 0);
    chk(tx_empty_evt_o === 1'b1 && wr_ready_o === 1'b1 && tx_valid_o === 1'b0,
        "R11", "empty event and ready after last byte",
        {tx_empty_evt_o, wr_ready_o, tx_valid_o}, 3'b110);
    @(negedge clk);
    chk(tx_empty_evt_o === 1'b0, "R11", "empty event width", tx_empty_evt_o, 0);
    bfill = 0;
  endtask

  task automatic t_reset_and_kick();
    chk(tx_valid_o === 0 && wr_ready_o === 1 && tx_empty_evt_o === 0 && tx_err_evt_o === 0,
        "R1", "reset outputs", {tx_valid_o, wr_ready_o, tx_empty_evt_o, tx_err_evt_o}, 4'b0100);
    wr(32'h2211_0000); wr(32'h6655_4433); wr(32'hAA99_8877); wr(32'hEEDD_CCBB); wr(32'h1234_5678);
    chk(tx_valid_o === 0, "R4", "no send with threshold at reset value", tx_valid_o, 0);
    kick(32'hFFFF_FFFE);
    chk(tx_valid_o === 0, "R6", "trigger with bit0 clear", tx_valid_o, 0);
    kick(32'h0000_0001);
    chk(tx_valid_o === 1, "R6", "trigger with bit0 set", tx_valid_o, 1);
    recv(14, 14, "R7", 1);
  endtask

  task automatic t_len_err();
    wr(32'h0000_07F1);
    chk(tx_err_evt_o === 1, "R2", "error on length 2033", tx_err_evt_o, 1);
    wr(32'h0000_07F0);
    chk(tx_err_evt_o === 0, "R2", "length 2032 accepted", tx_err_evt_o, 0);
    err_ack_i = 1; @(negedge clk); err_ack_i = 0;
    bfill = 0;
    wr(32'hAABB_0003); wr(32'h0403_0201); wr(32'h0807_0605); wr(32'h0C0B_0A09); wr(32'h100F_0E0D);
    kick(32'h1);
    recv(17, 17, "R12", 0);
  endtask

  task automatic t_auto();
    set_thr(6'd0);
    crc_auto_i = 1;
    wr(32'h0101_0004);
    for (int i = 1; i < 4; i++) wr(32'h1000_0000 + i);
    chk(tx_valid_o === 0, "R3", "incomplete at 16 bytes with auto-CRC", tx_valid_o, 0);
    wr(32'h2000_0005);
    chk(tx_valid_o === 1, "R5", "auto send after completing write", tx_valid_o, 1);
    recv(18, 18, "R5", 1);
    crc_auto_i = 0;
    wr(32'h0202_0004);
    for (int i = 1; i < 5; i++) wr(32'h3000_0000 + i);
    chk(tx_valid_o === 0, "R3", "incomplete at 20 bytes without auto-CRC", tx_valid_o, 0);
    wr(32'h4000_0006);
    chk(tx_valid_o === 1, "R3", "complete at 24 bytes without auto-CRC", tx_valid_o, 1);
    recv(18, 18, "R3", 0);
    crc_auto_i = 1;
    set_thr(6'd1);
    wr(32'h0303_0004);
    for (int i = 1; i < 8; i++) wr(32'h5000_0000 + i);
    chk(tx_valid_o === 0, "R4", "below threshold 36 at 32 bytes", tx_valid_o, 0);
    wr(32'h6000_0009);
    chk(tx_valid_o === 1, "R4", "threshold 36 reached", tx_valid_o, 1);
    recv(18, 18, "R4", 1);
  endtask

  task automatic t_pad();
    set_thr(6'h3f);
    pad_en_i = 1;
    wr(32'hFFFF_000A);
    for (int i = 1; i < 7; i++) wr(32'hFFFF_FFFF);
    kick(32'h1);
    recv(60, 24, "R8", 1);
    pad_en_i = 0;
    wr(32'hFFFF_000A);
    for (int i = 1; i < 7; i++) wr(32'hFFFF_FFFF);
    kick(32'h1);
    recv(24, 24, "R8", 0);
  endtask

  task automatic t_overflow();
    crc_auto_i = 0;
    wr(32'h5A5A_07F0);
    for (int i = 1; i < 512; i++) wr((i * 32'h0101_0101) ^ 32'hC300_0000);
    chk(tx_valid_o === 0, "R4", "full buffer, threshold disabled", tx_valid_o, 0);
    set_thr(6'd0);
    wr(32'hDEAD_BEEF);
    chk(tx_valid_o === 1, "R3", "capped target met by dropped write", tx_valid_o, 1);
    recv(2046, 2046, "R9", 0);
    crc_auto_i = 1;
    set_thr(6'h3f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_and_kick();
    t_len_err();
    t_auto();
    t_pad();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run incomplete, got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule